// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block sequences the digital control of a 64-element linear light sensor. A start request, sampled on a rising clock edge while the block is idle, opens a run of exactly 66 clock cycles. During a run the block produces the per-cycle control strobes for the analog front end: a strobe that empties the integration capacitors, a strobe that precharges them, and a marker for the start of integration. It also drives a 64-bit vector that moves each pixel's sample-and-store element between hold and track. The analog integrators, sample capacitors, temperature sensor and output multiplexer sit outside the block; only their control lines are modelled here.

Readout is pipelined. Each run presents on the analog output the samples captured during the previous run, one pixel per cycle, with a temperature slot at the start and the end of the run. Pixels leave hold one at a time, each on the cycle after its stored value has been presented. Because the storage elements hold nothing meaningful after power-up, the first run after reset is marked as an initialization run. An inhibit input blocks new runs and silences the strobes.

Top module: `linscan_seq`

## Requirements
- R1: When the block is idle (cycle_o = 0), a rising clock edge that samples start_i = 1 and inhibit_i = 0 starts a run, and cycle_o reads 1 in the following cycle.
- R2: Within a run cycle_o counts 1, 2, … 66, one step per clock, and busy_o is 1 exactly when cycle_o is nonzero; after cycle 66 with no new start the block returns to idle (cycle_o = 0).
- R3: In cycle 1, discharge_o is 1 (unless inhibited), sel_temp_o is 1 and every bit of track_en_o is 0 (hold).
- R4: precharge_o and integ_start_o are 1 in cycle 2 only (unless inhibited); discharge_o is 1 in cycle 1 only.
- R5: In cycle k+2, for k = 0 … 63, sel_pix_valid_o is 1 and sel_pix_o equals k; sel_pix_valid_o and sel_temp_o are never 1 together and both are 0 in idle.
- R6: Bit k of track_en_o becomes 1 in cycle k+3 and stays 1, through idle, until cycle 1 of the next run; in cycle c ≥ 3 exactly c−2 bits are set.
- R7: In cycle 66, sel_temp_o is 1 and sel_pix_valid_o is 0.
- R8: init_run_o is 1 from reset until the end of the first completed run and 0 from then on.
- R9: start_i is ignored during cycles 1 to 65 of a run: the count advances normally.
- R10: start_i = 1 with inhibit_i = 0 sampled at the end of cycle 66 begins the next run directly, so cycle_o reads 1 in the next cycle with no idle cycle between runs.
- R11: While inhibit_i is 1, no run starts from idle, and discharge_o, precharge_o and integ_start_o are 0.
- R12: Synchronous active-high reset sets cycle_o = 0, busy_o = 0, track_en_o = 0 and init_run_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Run request, sampled on the rising edge |
| inhibit_i | input | 1 | Blocks new runs and silences strobes when 1 |
| busy_o | output | 1 | A run is in progress |
| cycle_o | output | 7 | Cycle within the run, 1 to 66; 0 when idle |
| track_en_o | output | 64 | Per-pixel track (1) / hold (0) control |
| discharge_o | output | 1 | Empty the integration capacitors |
| precharge_o | output | 1 | Precharge the integration capacitors |
| integ_start_o | output | 1 | Integration of all pixels begins this cycle |
| sel_temp_o | output | 1 | Analog output shows the temperature channel |
| sel_pix_valid_o | output | 1 | Analog output shows a stored pixel sample |
| sel_pix_o | output | 6 | Index of the pixel sample shown |
| init_run_o | output | 1 | Current run is the initialization run |

## Verification
The checks assume start_i and inhibit_i are synchronous to clk and stable around the rising edge, and that reset is held for at least one edge before any run is requested. The strobe-silencing property further takes inhibit_i as a level that may change at any cycle boundary, so the stimulus drives both inputs once per cycle just after the falling edge. The stimulus covers idle with inhibit set, a start pulse in the middle of a run, a run followed immediately by the next one, and inhibit raised during cycle 2 of a running run.

// File: rtl/linscan_pkg.sv
package linscan_pkg;

    // Default geometry of the sensor line.
    localparam int unsigned LS_NPIX = 64;

    // What the analog output multiplexer is pointed at.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TEMP = 2'd1,
        SEL_PIX  = 2'd2
    } sel_kind_e;

endpackage

// File: rtl/linscan_ctr.sv
module linscan_ctr #(
    parameter int unsigned NPIX = linscan_pkg::LS_NPIX,
    localparam int unsigned LAST = NPIX + 2,
    localparam int unsigned CW   = $clog2(LAST + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          inhibit,
    output logic [CW-1:0] cyc_q,
    output logic [CW-1:0] cyc_nxt,
    output logic          init_q
);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic          init;
    } ctr_st_t;

    localparam logic [CW-1:0] CYC_LAST = CW'(LAST);
    localparam logic [CW-1:0] CYC_ONE  = CW'(1);

    ctr_st_t st_d, st_q;
    logic    go;

    always_comb begin
        st_d = st_q;
        go   = start && !inhibit;
        if (st_q.cyc == '0) begin
            if (go) st_d.cyc = CYC_ONE;
        end else if (st_q.cyc == CYC_LAST) begin
            st_d.init = 1'b0;
            st_d.cyc  = go ? CYC_ONE : '0;
        end else begin
            st_d.cyc = st_q.cyc + CYC_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cyc  <= '0;
            st_q.init <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_q   = st_q.cyc;
    assign cyc_nxt = st_d.cyc;
    assign init_q  = st_q.init;

    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == '0 && start && !inhibit) |=> cyc_q == CYC_ONE);

    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != '0 && cyc_q != CYC_LAST) |=> cyc_q == $past(cyc_q) + CYC_ONE);

    p_end_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == CYC_LAST && !start) |=> cyc_q == '0);

    p_chain_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == CYC_LAST && start && !inhibit) |=> cyc_q == CYC_ONE);

    p_blocked_r11: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == '0 && inhibit) |=> cyc_q == '0);

    p_init_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == CYC_LAST) |=> !init_q);

endmodule

// File: rtl/linscan_track.sv
module linscan_track #(
    parameter int unsigned NPIX = linscan_pkg::LS_NPIX,
    parameter int unsigned CW   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cyc_nxt,
    output logic [NPIX-1:0] trk_q
);

    logic [NPIX-1:0] trk_d;
    logic [NPIX-1:0] set_hit;
    logic            clr_all;

    // Pixel k is released to track on the cycle numbered k+3.
    for (genvar k = 0; k < NPIX; k++) begin : g_hit
        assign set_hit[k] = (cyc_nxt == CW'(k + 3));
    end

    always_comb begin
        clr_all = (cyc_nxt == CW'(1));
        trk_d   = clr_all ? '0 : (trk_q | set_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

    p_single_step_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(trk_q & ~$past(trk_q)) <= 1);

endmodule

// File: rtl/linscan_mux.sv
module linscan_mux #(
    parameter int unsigned NPIX = linscan_pkg::LS_NPIX,
    parameter int unsigned CW   = 7,
    localparam int unsigned PW  = $clog2(NPIX)
) (
    input  logic [CW-1:0] cyc_q,
    input  logic          inhibit,
    output logic          discharge,
    output logic          precharge,
    output logic          integ_start,
    output logic          sel_temp,
    output logic          sel_pix_valid,
    output logic [PW-1:0] sel_pix
);
    import linscan_pkg::*;

    localparam logic [CW-1:0] CYC_LAST = CW'(NPIX + 2);

    sel_kind_e     kind;
    logic [CW-1:0] off;

    always_comb begin
        off = cyc_q - CW'(2);
        if (cyc_q == CW'(1) || cyc_q == CYC_LAST)        kind = SEL_TEMP;
        else if (cyc_q >= CW'(2) && cyc_q < CYC_LAST)    kind = SEL_PIX;
        else                                             kind = SEL_NONE;

        sel_temp      = (kind == SEL_TEMP);
        sel_pix_valid = (kind == SEL_PIX);
        sel_pix       = sel_pix_valid ? off[PW-1:0] : '0;

        discharge   = !inhibit && (cyc_q == CW'(1));
        precharge   = !inhibit && (cyc_q == CW'(2));
        integ_start = precharge;
    end

endmodule

// File: rtl/linscan_seq.sv
module linscan_seq #(
    parameter int unsigned NPIX = linscan_pkg::LS_NPIX,
    localparam int unsigned CW  = $clog2(NPIX + 3),
    localparam int unsigned PW  = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            inhibit_i,
    output logic            busy_o,
    output logic [CW-1:0]   cycle_o,
    output logic [NPIX-1:0] track_en_o,
    output logic            discharge_o,
    output logic            precharge_o,
    output logic            integ_start_o,
    output logic            sel_temp_o,
    output logic            sel_pix_valid_o,
    output logic [PW-1:0]   sel_pix_o,
    output logic            init_run_o
);

    logic [CW-1:0] cyc_q;
    logic [CW-1:0] cyc_nxt;

    linscan_ctr #(.NPIX(NPIX)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .inhibit (inhibit_i),
        .cyc_q   (cyc_q),
        .cyc_nxt (cyc_nxt),
        .init_q  (init_run_o)
    );

    linscan_track #(.NPIX(NPIX), .CW(CW)) u_track (
        .clk     (clk),
        .rst     (rst),
        .cyc_nxt (cyc_nxt),
        .trk_q   (track_en_o)
    );

    linscan_mux #(.NPIX(NPIX), .CW(CW)) u_mux (
        .cyc_q         (cyc_q),
        .inhibit       (inhibit_i),
        .discharge     (discharge_o),
        .precharge     (precharge_o),
        .integ_start   (integ_start_o),
        .sel_temp      (sel_temp_o),
        .sel_pix_valid (sel_pix_valid_o),
        .sel_pix       (sel_pix_o)
    );

    assign cycle_o = cyc_q;
    assign busy_o  = (cyc_q != '0);

    p_hold_first_r3: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == CW'(1)) |-> (track_en_o == '0 && sel_temp_o));

    p_track_count_r6: assert property (@(posedge clk) disable iff (rst)
        (cycle_o >= CW'(3)) |-> ($countones(track_en_o) == int'(cycle_o) - 2));

    p_sel_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_temp_o, sel_pix_valid_o}));

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |-> !(discharge_o || precharge_o || integ_start_o));

    p_pix_step_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_pix_valid_o && $past(sel_pix_valid_o)) |-> sel_pix_o == $past(sel_pix_o) + PW'(1));

endmodule

// File: tb/linscan_seq_bench.sv
module linscan_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 64;
    localparam int LAST = NPIX + 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        inhibit_i;
    logic        busy_o;
    logic [6:0]  cycle_o;
    logic [63:0] track_en_o;
    logic        discharge_o, precharge_o, integ_start_o;
    logic        sel_temp_o, sel_pix_valid_o;
    logic [5:0]  sel_pix_o;
    logic        init_run_o;

    linscan_seq u_linscan_seq (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .inhibit_i       (inhibit_i),
        .busy_o          (busy_o),
        .cycle_o         (cycle_o),
        .track_en_o      (track_en_o),
        .discharge_o     (discharge_o),
        .precharge_o     (precharge_o),
        .integ_start_o   (integ_start_o),
        .sel_temp_o      (sel_temp_o),
        .sel_pix_valid_o (sel_pix_valid_o),
        .sel_pix_o       (sel_pix_o),
        .init_run_o      (init_run_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        bit          busy, disc, pre, integ, temp, pv, init, inh;
        int          pix;
        logic [63:0] trk;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int          m_cyc  = 0;
    logic [63:0] m_trk  = '0;
    bit          m_init = 1'b1;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies inputs for one cycle and queues the outputs the
    // requirements predict after the next rising edge.
    task automatic tick(bit st, bit inh, string tag);
        exp_t e;
        int   nc;
        @(negedge clk);
        #1;
        start_i   = st;
        inhibit_i = inh;
        if (m_cyc == 0)         nc = (st && !inh) ? 1 : 0;
        else if (m_cyc == LAST) begin
            nc     = (st && !inh) ? 1 : 0;
            m_init = 1'b0;
        end else                nc = m_cyc + 1;
        if (nc == 1)       m_trk = '0;
        else if (nc >= 3)  m_trk[nc-3] = 1'b1;
        m_cyc   = nc;
        e.cyc   = nc;
        e.busy  = (nc != 0);
        e.disc  = (nc == 1) && !inh;
        e.pre   = (nc == 2) && !inh;
        e.integ = (nc == 2) && !inh;
        e.temp  = (nc == 1) || (nc == LAST);
        e.pv    = (nc >= 2) && (nc < LAST);
        e.pix   = e.pv ? nc - 2 : 0;
        e.trk   = m_trk;
        e.init  = m_init;
        e.inh   = inh;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares the oldest prediction at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(e.tag, "cycle", 64'(cycle_o), 64'(e.cyc));
            chk("R2", "busy", 64'(busy_o), 64'(e.busy));
            chk(e.inh ? "R11" : "R3", "discharge", 64'(discharge_o), 64'(e.disc));
            chk(e.inh ? "R11" : "R4", "precharge", 64'(precharge_o), 64'(e.pre));
            chk(e.inh ? "R11" : "R4", "integ_start", 64'(integ_start_o), 64'(e.integ));
            chk(e.cyc == LAST ? "R7" : "R3", "sel_temp", 64'(sel_temp_o), 64'(e.temp));
            chk("R5", "sel_pix_valid", 64'(sel_pix_valid_o), 64'(e.pv));
            if (e.pv) chk("R5", "sel_pix", 64'(sel_pix_o), 64'(e.pix));
            chk("R6", "track_en", track_en_o, e.trk);
            chk("R8", "init_run", 64'(init_run_o), 64'(e.init));
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        start_i   = 1'b1;
        inhibit_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12", "cycle", 64'(cycle_o), 64'd0);
        chk("R12", "busy", 64'(busy_o), 64'd0);
        chk("R12", "track_en", track_en_o, 64'd0);
        chk("R12", "init_run", 64'(init_run_o), 64'd1);
        #1;
        rst     = 1'b0;
        start_i = 1'b0;

        repeat (3) tick(1'b0, 1'b0, "R2");
        // R11: inhibit blocks a start from idle
        tick(1'b1, 1'b1, "R11");
        tick(1'b1, 1'b1, "R11");
        // R1: first run (initialization run)
        tick(1'b1, 1'b0, "R1");
        for (int i = 2; i <= LAST; i++)
            tick(i == 10, 1'b0, (i == 10) ? "R9" : "R2");
        // R6: all pixels stay in track through idle
        repeat (3) tick(1'b0, 1'b0, "R6");
        // second run, chained directly into a third (R10)
        tick(1'b1, 1'b0, "R1");
        for (int i = 2; i <= LAST; i++) tick(1'b0, 1'b0, "R2");
        tick(1'b1, 1'b0, "R10");
        // R11: inhibit raised during cycle 2 silences the strobes
        tick(1'b0, 1'b1, "R11");
        for (int i = 3; i <= LAST; i++) tick(1'b0, 1'b0, "R8");
        tick(1'b0, 1'b0, "R2");
        tick(1'b0, 1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule